// File: doc/BRIEF.md
# Ping-Pong Block DMA Channel

This block is a single DMA transfer channel that copies data between a dual-port buffer RAM and one fixed peripheral register address. Each transfer moves a 16-bit word or a single byte, in either direction. Software programs six small registers through a write port: a control word, a request-source selector (which also carries a software force bit), two buffer start offsets, the peripheral address and a transfer count.

Transfers are grouped into blocks of count+1 transfers. Once a block completes, the channel either disables itself (one-shot), reloads the RAM address from the start offset (continuous), or switches to the other of two start offsets so that two buffers are filled alternately (ping-pong). An interrupt pulse marks the end of each block, or instead the half-block point. A transfer is launched by a pulse on the selected peripheral request line or by the software force bit. Each transfer takes one read cycle on the source side followed by one write cycle on the destination side.

Top module: `dma_pp_channel`

## Requirements
- R1: After reset, busy_o, irq_o, chan_en_o, buf_sel_o and all four bus strobes are 0.
- R2: A trigger accepted by an enabled, idle channel at a clock edge gives exactly one source read cycle right after that edge and one destination write cycle in the next cycle. busy_o is high in both cycles, and the data written is the data read (registered single-cycle read data).
- R3: Control bit 2 (cfg_sel 0) selects the direction: 1 means RAM read then peripheral write at per_addr_o; 0 means peripheral read then RAM write. The peripheral address is programmed with cfg_sel 4.
- R4: Control bit 1 selects byte transfers. A RAM byte is the lane chosen by address bit 0 (0 = bits 7:0, 1 = bits 15:8). A byte going to the peripheral is zero-extended. A byte going to RAM is replicated on both lanes with ram_be_o = 01 for even addresses and 10 for odd ones. Word transfers use ram_be_o = 11.
- R5: The RAM address starts at the primary offset (cfg_sel 2). It rises by 2 per word transfer or by 1 per byte transfer, or stays fixed when control bit 3 is set.
- R6: A block is count+1 transfers, with the count in cfg_sel 5 (10 bits). Without half mode, irq_o is high for one cycle, right after the write cycle of the block's last transfer.
- R7: With control bit 4 (one-shot) set, chan_en_o falls right after the last write of a block. Later triggers then give no read cycle.
- R8: Without one-shot, the channel stays enabled and the first transfer of the next block uses the start offset again.
- R9: With control bit 5 (ping-pong) set, successive blocks start at the primary and then the secondary (cfg_sel 3) offset. buf_sel_o (0 = primary) toggles right after each block's last write.
- R10: With control bit 6 (half mode) set, irq_o pulses only after transfer number ceil((count+1)/2) of each block, and not at block end.
- R11: Control bit 0 enables the channel; writing it as 1 restarts at the primary buffer. The trigger is the request line whose index is written to bits 2:0 of cfg_sel 1. Writing bit 15 of cfg_sel 1 forces one transfer, whose read cycle comes two cycles after the write edge. Unselected request lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 request select/force, 2 primary offset, 3 secondary offset, 4 peripheral address, 5 count |
| cfg_wdata | input | 16 | Register write data |
| req_i | input | NREQ | Peripheral request pulses |
| ram_addr_o | output | AW | RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_be_o | output | 2 | RAM byte-lane enables |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, valid the cycle after ram_rd_o |
| per_addr_o | output | PW | Peripheral register address |
| per_rd_o | output | 1 | Peripheral read strobe |
| per_wr_o | output | 1 | Peripheral write strobe |
| per_wdata_o | output | 16 | Peripheral write data |
| per_rdata_i | input | 16 | Peripheral read data, valid the cycle after per_rd_o |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Block-end or half-block interrupt pulse |
| chan_en_o | output | 1 | Channel enable state |
| buf_sel_o | output | 1 | Ping-pong buffer in use (0 primary) |

## Verification
A request pulse sampled at one edge puts the read strobe in the next cycle and the write strobe with its address and data one cycle later. The interrupt, the buffer flag and the enable flag change at the edge that closes the write cycle. A force write adds one cycle ahead of the read. The bench drives inputs and samples outputs on falling edges, and steps one cycle between these points, so each result is read in the cycle it is due. The ping-pong sequence is walked as a vector table, and the byte lanes, the fixed address, one-shot, half mode, force and the unselected line are tested directly.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_t;

   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_REQ  = 3'd1;
   localparam logic [2:0] SEL_STA  = 3'd2;
   localparam logic [2:0] SEL_STB  = 3'd3;
   localparam logic [2:0] SEL_PAD  = 3'd4;
   localparam logic [2:0] SEL_CNT  = 3'd5;

   // control word bits 6:1; bit 0 (enable) is held separately
   typedef struct packed {
      logic halfirq;
      logic pingpong;
      logic oneshot;
      logic fixed;
      logic to_per;
      logic byte_sz;
   } ctrl_t;
endpackage

// File: rtl/dma_pp_regs.sv
module dma_pp_regs
   import dma_pp_pkg::*;
#(
   parameter int AW   = 11,
   parameter int PW   = 16,
   parameter int CW   = 10,
   parameter int RSW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [2:0]     sel,
   input  logic [15:0]    wdata,
   input  logic           clr_en,
   output logic           en_q,
   output logic           arm,
   output logic           force_q,
   output ctrl_t          ctrl,
   output logic [RSW-1:0] reqsel,
   output logic [AW-1:0]  sta,
   output logic [AW-1:0]  stb,
   output logic [PW-1:0]  pad,
   output logic [CW-1:0]  cnt
);
   logic ctrl_wr;
   assign ctrl_wr = we && (sel == SEL_CTRL);
   assign arm     = ctrl_wr && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         force_q <= 1'b0;
         ctrl    <= '0;
         reqsel  <= '0;
         sta     <= '0;
         stb     <= '0;
         pad     <= '0;
         cnt     <= '0;
      end else begin
         force_q <= we && (sel == SEL_REQ) && wdata[15];
         if (ctrl_wr) begin
            en_q <= wdata[0];
            ctrl <= ctrl_t'(wdata[6:1]);
         end else if (clr_en) begin
            en_q <= 1'b0;
         end
         if (we) begin
            case (sel)
               SEL_REQ: reqsel <= wdata[RSW-1:0];
               SEL_STA: sta    <= wdata[AW-1:0];
               SEL_STB: stb    <= wdata[AW-1:0];
               SEL_PAD: pad    <= wdata[PW-1:0];
               SEL_CNT: cnt    <= wdata[CW-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dma_pp_addr.sv
module dma_pp_addr #(
   parameter int AW = 11,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          byte_sz,
   input  logic          fixed,
   input  logic          pingpong,
   input  logic [AW-1:0] sta,
   input  logic [AW-1:0] stb,
   input  logic [CW-1:0] cnt_lim,
   output logic [AW-1:0] cur_addr,
   output logic          pp,
   output logic          last,
   output logic          half
);
   localparam int CW1 = CW + 1;

   logic [CW-1:0]  xfer;
   logic [CW1-1:0] mid;
   logic [AW-1:0]  inc;

   assign inc  = byte_sz ? AW'(1) : AW'(2);
   assign last = (xfer == cnt_lim);
   assign mid  = ({1'b0, cnt_lim} + CW1'(2)) >> 1;
   assign half = (({1'b0, xfer} + CW1'(1)) == mid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         xfer     <= '0;
         pp       <= 1'b0;
      end else if (load) begin
         cur_addr <= sta;
         xfer     <= '0;
         pp       <= 1'b0;
      end else if (step) begin
         if (last) begin
            xfer <= '0;
            if (pingpong) begin
               pp       <= ~pp;
               cur_addr <= pp ? sta : stb;
            end else begin
               cur_addr <= sta;
            end
         end else begin
            xfer <= xfer + CW'(1);
            if (!fixed) cur_addr <= cur_addr + inc;
         end
      end
   end
endmodule

// File: rtl/dma_pp_seq.sv
module dma_pp_seq
   import dma_pp_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          byte_sz,
   input  logic          to_per,
   input  logic [AW-1:0] cur_addr,
   input  logic [15:0]   ram_rdata,
   input  logic [15:0]   per_rdata,
   output logic          idle,
   output logic          step,
   output logic          ram_rd,
   output logic          ram_wr,
   output logic [1:0]    ram_be,
   output logic [15:0]   ram_wdata,
   output logic          per_rd,
   output logic          per_wr,
   output logic [15:0]   per_wdata
);
   seq_t st;
   logic [7:0] ram_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else begin
         case (st)
            ST_IDLE: if (go) st <= ST_RD;
            ST_RD:   st <= ST_WR;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign idle   = (st == ST_IDLE);
   assign step   = (st == ST_WR);
   assign ram_rd = (st == ST_RD) && to_per;
   assign per_rd = (st == ST_RD) && !to_per;
   assign ram_wr = (st == ST_WR) && !to_per;
   assign per_wr = (st == ST_WR) && to_per;

   assign ram_byte = cur_addr[0] ? ram_rdata[15:8] : ram_rdata[7:0];

   always_comb begin
      if (byte_sz) begin
         per_wdata = {8'h00, ram_byte};
         ram_wdata = {per_rdata[7:0], per_rdata[7:0]};
         ram_be    = cur_addr[0] ? 2'b10 : 2'b01;
      end else begin
         per_wdata = ram_rdata;
         ram_wdata = per_rdata;
         ram_be    = 2'b11;
      end
   end
endmodule

// File: rtl/dma_pp_channel.sv
module dma_pp_channel
   import dma_pp_pkg::*;
#(
   parameter int AW   = 11,
   parameter int PW   = 16,
   parameter int CW   = 10,
   parameter int NREQ = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_sel,
   input  logic [15:0]     cfg_wdata,
   input  logic [NREQ-1:0] req_i,
   output logic [AW-1:0]   ram_addr_o,
   output logic            ram_rd_o,
   output logic            ram_wr_o,
   output logic [1:0]      ram_be_o,
   output logic [15:0]     ram_wdata_o,
   input  logic [15:0]     ram_rdata_i,
   output logic [PW-1:0]   per_addr_o,
   output logic            per_rd_o,
   output logic            per_wr_o,
   output logic [15:0]     per_wdata_o,
   input  logic [15:0]     per_rdata_i,
   output logic            busy_o,
   output logic            irq_o,
   output logic            chan_en_o,
   output logic            buf_sel_o
);
   localparam int RSW = $clog2(NREQ);

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 2..16");
   end
   if (PW < 1 || PW > 16) begin : g_bad_pw
      $error("PW must lie in 1..16");
   end
   if (CW < 1 || CW > 15) begin : g_bad_cw
      $error("CW must lie in 1..15");
   end
   if (NREQ < 2 || NREQ > 8 || (1 << RSW) != NREQ) begin : g_bad_nreq
      $error("NREQ must be 2, 4 or 8");
   end

   ctrl_t          ctrl;
   logic           en_q, arm, force_q, clr_en;
   logic [RSW-1:0] reqsel;
   logic [AW-1:0]  sta, stb, cur_addr;
   logic [CW-1:0]  cnt;
   logic           idle, step, last, half, pp, go, irq_q;

   dma_pp_regs #(.AW(AW), .PW(PW), .CW(CW), .RSW(RSW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .clr_en(clr_en), .en_q(en_q), .arm(arm), .force_q(force_q), .ctrl(ctrl),
      .reqsel(reqsel), .sta(sta), .stb(stb), .pad(per_addr_o), .cnt(cnt)
   );

   dma_pp_addr #(.AW(AW), .CW(CW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(arm), .step(step),
      .byte_sz(ctrl.byte_sz), .fixed(ctrl.fixed), .pingpong(ctrl.pingpong),
      .sta(sta), .stb(stb), .cnt_lim(cnt),
      .cur_addr(cur_addr), .pp(pp), .last(last), .half(half)
   );

   assign go = en_q && idle && (req_i[reqsel] || force_q);

   dma_pp_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .byte_sz(ctrl.byte_sz), .to_per(ctrl.to_per),
      .cur_addr(cur_addr), .ram_rdata(ram_rdata_i), .per_rdata(per_rdata_i),
      .idle(idle), .step(step), .ram_rd(ram_rd_o), .ram_wr(ram_wr_o),
      .ram_be(ram_be_o), .ram_wdata(ram_wdata_o), .per_rd(per_rd_o),
      .per_wr(per_wr_o), .per_wdata(per_wdata_o)
   );

   assign clr_en = step && last && ctrl.oneshot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= step && (ctrl.halfirq ? half : last);
   end

   assign ram_addr_o = cur_addr;
   assign busy_o     = !idle;
   assign irq_o      = irq_q;
   assign chan_en_o  = en_q;
   assign buf_sel_o  = pp;
endmodule

// File: rtl/dma_pp_chk.sv
module dma_pp_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_we,
   input logic ram_rd_o,
   input logic ram_wr_o,
   input logic per_rd_o,
   input logic per_wr_o,
   input logic busy_o,
   input logic irq_o,
   input logic chan_en_o,
   input logic buf_sel_o
);
   logic rd_any, wr_any;
   assign rd_any = ram_rd_o || per_rd_o;
   assign wr_any = ram_wr_o || per_wr_o;

   a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> wr_any);
   a_r2_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any || wr_any) |-> busy_o);
   a_r3_ram_to_per: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |=> per_wr_o);
   a_r3_per_to_ram: assert property (@(posedge clk) disable iff (!rst_n)
      per_rd_o |=> ram_wr_o);
   a_r6_irq_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(wr_any));
   a_r7_disable_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_en_o) |-> ($past(wr_any) || $past(cfg_we)));
   a_r9_buf_toggle_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(buf_sel_o) |-> ($past(wr_any) || $past(cfg_we)));
   a_r11_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en_o && !busy_o) |=> !busy_o);
endmodule

bind dma_pp_channel dma_pp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
   .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o), .per_rd_o(per_rd_o), .per_wr_o(per_wr_o),
   .busy_o(busy_o), .irq_o(irq_o), .chan_en_o(chan_en_o), .buf_sel_o(buf_sel_o)
);

// File: tb/sim_dma_pp_channel.sv
module sim_dma_pp_channel;
   localparam int AW = 11;
   localparam int PW = 16;
   localparam int NREQ = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_sel = '0;
   logic [15:0]     cfg_wdata = '0;
   logic [NREQ-1:0] req_i = '0;
   logic [AW-1:0]   ram_addr_o;
   logic            ram_rd_o, ram_wr_o, per_rd_o, per_wr_o;
   logic [1:0]      ram_be_o;
   logic [15:0]     ram_wdata_o, per_wdata_o;
   logic [15:0]     ram_rdata_i = '0;
   logic [15:0]     per_rdata_i = '0;
   logic [PW-1:0]   per_addr_o;
   logic            busy_o, irq_o, chan_en_o, buf_sel_o;

   logic [15:0] mem [64];
   logic [15:0] per_src = '0;
   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dma_pp_channel #(.AW(AW), .PW(PW), .CW(10), .NREQ(NREQ)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_i(req_i), .ram_addr_o(ram_addr_o), .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o),
      .ram_be_o(ram_be_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
      .per_addr_o(per_addr_o), .per_rd_o(per_rd_o), .per_wr_o(per_wr_o),
      .per_wdata_o(per_wdata_o), .per_rdata_i(per_rdata_i), .busy_o(busy_o),
      .irq_o(irq_o), .chan_en_o(chan_en_o), .buf_sel_o(buf_sel_o)
   );

   // bench RAM and peripheral models, single-cycle registered reads
   always @(posedge clk) begin
      if (ram_rd_o) ram_rdata_i <= mem[ram_addr_o[6:1]];
      if (ram_wr_o) begin
         if (ram_be_o[0]) mem[ram_addr_o[6:1]][7:0]  <= ram_wdata_o[7:0];
         if (ram_be_o[1]) mem[ram_addr_o[6:1]][15:8] <= ram_wdata_o[15:8];
      end
      if (per_rd_o) per_rdata_i <= per_src;
   end

   // ping-pong vectors: {peripheral data[15:0], RAM address[10:0], irq, buf_sel}
   localparam logic [28:0] VEC [7] = '{
      {16'hA001, 11'h010, 1'b0, 1'b0},
      {16'hA002, 11'h012, 1'b0, 1'b0},
      {16'hA003, 11'h014, 1'b1, 1'b1},
      {16'hB004, 11'h040, 1'b0, 1'b1},
      {16'hB005, 11'h042, 1'b0, 1'b1},
      {16'hB006, 11'h044, 1'b1, 1'b0},
      {16'hC007, 11'h010, 1'b0, 1'b0}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [2:0] sel, input logic [15:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      tick();
      cfg_we = 1'b0;
   endtask

   // one transfer: trigger, read cycle, write cycle, then the cycle after
   task automatic xfer(input bit use_force, input int line, input bit to_per,
                       input logic [10:0] e_addr, input logic [15:0] e_data,
                       input logic [1:0] e_be, input bit e_irq, input string tag);
      if (use_force) begin
         wr_cfg(3'd1, 16'h8000 | 16'(line));
         tick();
      end else begin
         req_i[line] = 1'b1;
         tick();
         req_i[line] = 1'b0;
      end
      chk({tag, " R2 busy in read"}, 32'(busy_o), 32'd1);
      chk({tag, " R3 read side"}, 32'(to_per ? ram_rd_o : per_rd_o), 32'd1);
      tick();
      chk({tag, " R2 write strobe"}, 32'(to_per ? per_wr_o : ram_wr_o), 32'd1);
      chk({tag, " R5 address"}, 32'(ram_addr_o), 32'(e_addr));
      chk({tag, " R2 data"}, 32'(to_per ? per_wdata_o : ram_wdata_o), 32'(e_data));
      if (!to_per) chk({tag, " R4 lanes"}, 32'(ram_be_o), 32'(e_be));
      tick();
      chk({tag, " R6 irq"}, 32'(irq_o), 32'(e_irq));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 enable", 32'(chan_en_o), 0);
      chk("R1 buffer", 32'(buf_sel_o), 0);
      chk("R1 strobes", 32'({ram_rd_o, ram_wr_o, per_rd_o, per_wr_o}), 0);
      rst_n = 1'b1;
      tick();

      // R9 R8 ping-pong continuous, word, peripheral to RAM, count 2
      wr_cfg(3'd2, 16'h0010);
      wr_cfg(3'd3, 16'h0040);
      wr_cfg(3'd4, 16'h0123);
      wr_cfg(3'd5, 16'd2);
      wr_cfg(3'd1, 16'd2);
      wr_cfg(3'd0, 16'h0021);
      chk("R11 enabled", 32'(chan_en_o), 1);
      chk("R3 peripheral address", 32'(per_addr_o), 32'h0123);
      for (int v = 0; v < 7; v++) begin
         per_src = VEC[v][28:13];
         xfer(1'b0, 2, 1'b0, VEC[v][12:2], VEC[v][28:13], 2'b11, VEC[v][1], "R9 vec");
         chk("R9 buffer select", 32'(buf_sel_o), 32'(VEC[v][0]));
      end
      chk("R8 still enabled", 32'(chan_en_o), 1);

      // R11 unselected request line has no effect
      req_i[5] = 1'b1;
      tick();
      req_i[5] = 1'b0;
      chk("R11 unselected line", 32'(busy_o), 0);
      chk("R11 unselected no read", 32'(per_rd_o), 0);

      // R4 R7 one-shot, byte, RAM to peripheral, odd start, count 1
      wr_cfg(3'd2, 16'h0013);
      wr_cfg(3'd5, 16'd1);
      wr_cfg(3'd0, 16'h0017);
      xfer(1'b0, 2, 1'b1, 11'h013, 16'h00A0, 2'b00, 1'b0, "R4 high lane");
      chk("R7 enabled mid block", 32'(chan_en_o), 1);
      xfer(1'b0, 2, 1'b1, 11'h014, 16'h0003, 2'b00, 1'b1, "R4 low lane");
      chk("R7 one-shot disables", 32'(chan_en_o), 0);
      req_i[2] = 1'b1;
      tick();
      req_i[2] = 1'b0;
      chk("R7 ignored when disabled", 32'(busy_o), 0);
      chk("R7 no read when disabled", 32'(ram_rd_o), 0);

      // R5 R4 fixed address, byte, peripheral to RAM, continuous, count 1
      wr_cfg(3'd2, 16'h0031);
      wr_cfg(3'd0, 16'h000B);
      per_src = 16'h77C5;
      xfer(1'b0, 2, 1'b0, 11'h031, 16'hC5C5, 2'b10, 1'b0, "R5 fixed 1");
      per_src = 16'h11D6;
      xfer(1'b0, 2, 1'b0, 11'h031, 16'hD6D6, 2'b10, 1'b1, "R5 fixed 2");
      chk("R8 continuous stays enabled", 32'(chan_en_o), 1);
      xfer(1'b0, 2, 1'b0, 11'h031, 16'hD6D6, 2'b10, 1'b0, "R8 fixed reload");
      chk("R4 RAM byte written", 32'(mem[6'h18]), 32'hD600);

      // R10 half mode, word, continuous, count 3 -> irq after transfer 2
      wr_cfg(3'd2, 16'h0050);
      wr_cfg(3'd5, 16'd3);
      wr_cfg(3'd0, 16'h0041);
      per_src = 16'h1234;
      xfer(1'b0, 2, 1'b0, 11'h050, 16'h1234, 2'b11, 1'b0, "R10 t1");
      xfer(1'b0, 2, 1'b0, 11'h052, 16'h1234, 2'b11, 1'b1, "R10 t2");
      xfer(1'b0, 2, 1'b0, 11'h054, 16'h1234, 2'b11, 1'b0, "R10 t3");
      xfer(1'b0, 2, 1'b0, 11'h056, 16'h1234, 2'b11, 1'b0, "R10 t4 no end irq");
      xfer(1'b0, 2, 1'b0, 11'h050, 16'h1234, 2'b11, 1'b0, "R8 reload t5");

      // R11 software force starts a transfer (half point of the new block)
      per_src = 16'h9ABC;
      xfer(1'b1, 2, 1'b0, 11'h052, 16'h9ABC, 2'b11, 1'b1, "R11 force");
      chk("R11 force single transfer", 32'(busy_o), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule